// File: doc/BRIEF.md
# Sector Lock Register Command Engine

This block is the device-side command logic of a serial NOR flash that holds one volatile lock entry per 64 KB sector. It oversamples a chip-select, serial clock and four-line data bus with a fast internal clock. It decodes three commands: write-enable, write-lock and read-lock.

The bus width is chosen by a mode input: one line, two lines or four lines. Commands, addresses and data all use the chosen width. A write-lock takes a command byte, three address bytes and one data byte. The write is committed only when chip-select rises directly after the last data bit and the write enable latch is set. A read-lock takes a command byte and three address bytes. It then shifts the addressed lock byte out on the data lines for as long as chip-select stays low.

An erase-suspend indication is present as an input. Lock commands work the same whether it is high or low.

Top module: `lock_reg_engine`

## Requirements
- R1: After reset every sector lock entry reads as 0, the write enable latch `wel` is 0, and `dq_oe` is 0.
- R2: `mode` selects the bus width: 0 is one line on dq_in[0], 1 is two lines on dq_in[1:0] (dq_in[1] more significant), 2 is four lines on dq_in[3:0] (dq_in[3] most significant), and 3 acts as 0. Bits are sampled on the rising edge of `sck` while `cs_n` is low, most significant first.
- R3: Command 0x06, followed by chip-select rising after exactly 8 bits, sets `wel` to 1.
- R4: Command 0xE5 with a 24-bit address and one data byte writes data bits [1:0] into the addressed sector. This happens only when `wel` is 1 and chip-select rises after exactly 40 bits, and it clears `wel`. Data bits [7:2] are not stored, and those bits of the lock byte read as 0.
- R5: A write-lock whose chip-select rises after any bit count other than 40, or that arrives while `wel` is 0, changes no lock entry and leaves `wel` unchanged.
- R6: Write-lock commits the same way while `erase_suspend` is 1.
- R7: For command 0xE8, the first chunk of the lock byte appears on the falling `sck` edge after the last address bit. That is after 32, 16 or 8 rising edges in one-, two- or four-line mode. The next chunk appears on each falling edge after that. The chunk goes on dq_out[1] with `dq_oe`=0010, on dq_out[1:0] with 0011, or on dq_out[3:0] with 1111, most significant first.
- R8: The addressed lock byte repeats for as long as `cs_n` stays low.
- R9: `dq_oe` is 0 at all times other than read-lock output. Any other command code is ignored until chip-select rises.
- R10: The sector is selected by address bits [22:16]. Address bit 23 and bits [15:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock, synchronous to clk |
| dq_in | input | 4 | Serial data in |
| mode | input | 2 | Bus width select |
| erase_suspend | input | 1 | Erase suspend in effect |
| dq_out | output | 4 | Serial data out |
| dq_oe | output | 4 | Per-line output enable |
| wel | output | 1 | Write enable latch |

## Verification
The hardest cases to reach are the framing corner cases: a write-lock that ends one bus chunk short of, or one chunk past, the data byte while the latch is set. The stimulus truncates or extends the data phase by one `sck` edge. It then checks that the latch is still 1 and reads the sector back to confirm the entry did not change. Address bit 23 and the data bits above bit 1 are driven with ones to show they are discarded.

// File: rtl/lock_reg_engine.sv
module lock_reg_engine #(
  parameter int SECTORS = 128,
  parameter int ADDR_W  = 24,
  parameter int SEC_LSB = 16,
  parameter logic [7:0] CMD_WREN = 8'h06,
  parameter logic [7:0] CMD_WRLK = 8'hE5,
  parameter logic [7:0] CMD_RDLK = 8'hE8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] dq_in,
  input  logic [1:0] mode,
  input  logic       erase_suspend,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe,
  output logic       wel
);
  localparam int SEC_W    = $clog2(SECTORS);
  localparam int SH_W     = ADDR_W + 8;
  localparam int ADDR_END = 8 + ADDR_W;
  localparam int DATA_END = ADDR_END + 8;
  localparam int NB_W     = $clog2(DATA_END + 8) + 1;

  logic            sck_q, cs_q;
  logic [SH_W-1:0] sh, sh_next;
  logic [NB_W-1:0] nbits, step;
  logic [7:0]      cmd;
  logic [SEC_W-1:0] sect;
  logic [1:0]      lock [SECTORS];
  logic            rd_act;
  logic [2:0]      oidx, olast, shamt;
  logic [7:0]      obyte, osh;

  wire sck_rise = sck & ~sck_q & ~cs_n;
  wire sck_fall = ~sck & sck_q & ~cs_n;
  wire cs_rise  = cs_n & ~cs_q;
  wire commit   = cs_rise && cmd == CMD_WRLK && nbits == NB_W'(DATA_END) && wel;

  always_comb begin
    case (mode)
      2'd1: begin
        sh_next = {sh[SH_W-3:0], dq_in[1:0]};
        step = NB_W'(2); olast = 3'd3; shamt = {oidx[1:0], 1'b0};
      end
      2'd2: begin
        sh_next = {sh[SH_W-5:0], dq_in[3:0]};
        step = NB_W'(4); olast = 3'd1; shamt = {oidx[0], 2'b00};
      end
      default: begin
        sh_next = {sh[SH_W-2:0], dq_in[0]};
        step = NB_W'(1); olast = 3'd7; shamt = oidx;
      end
    endcase
  end

  assign obyte = {6'b0, lock[sect]};
  assign osh   = obyte << shamt;

  always_comb begin
    dq_out = 4'b0;
    dq_oe  = 4'b0;
    if (rd_act && !cs_n) begin
      case (mode)
        2'd1:    begin dq_out = {2'b0, osh[7:6]}; dq_oe = 4'b0011; end
        2'd2:    begin dq_out = osh[7:4];         dq_oe = 4'b1111; end
        default: begin dq_out = {2'b0, osh[7], 1'b0}; dq_oe = 4'b0010; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      sh     <= '0;
      nbits  <= '0;
      cmd    <= 8'h00;
      sect   <= '0;
      rd_act <= 1'b0;
      oidx   <= 3'd0;
      wel    <= 1'b0;
      for (int i = 0; i < SECTORS; i++) lock[i] <= 2'b00;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        nbits  <= '0;
        rd_act <= 1'b0;
        oidx   <= 3'd0;
      end else begin
        if (sck_rise) begin
          sh <= sh_next;
          if (nbits <= NB_W'(DATA_END)) nbits <= nbits + step;
          if (nbits + step == NB_W'(8)) cmd <= sh_next[7:0];
          if (nbits + step == NB_W'(ADDR_END)) sect <= sh_next[SEC_LSB +: SEC_W];
        end
        if (sck_fall && cmd == CMD_RDLK && nbits >= NB_W'(ADDR_END)) begin
          if (!rd_act) begin
            rd_act <= 1'b1;
            oidx   <= 3'd0;
          end else begin
            oidx <= (oidx == olast) ? 3'd0 : oidx + 3'd1;
          end
        end
      end
      if (cs_rise && cmd == CMD_WREN && nbits == NB_W'(8)) wel <= 1'b1;
      if (commit) begin
        lock[sect] <= sh[1:0];
        wel        <= 1'b0;
      end
    end
  end

  AST_WEL_CLR_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !wel); // R4

  AST_WEL_ONLY_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(wel)); // R5

  AST_SUSPEND_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && erase_suspend) |=> !wel); // R6

  AST_OE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != 4'b0) |-> (cmd == CMD_RDLK && nbits >= NB_W'(ADDR_END))); // R7

  AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 4'b0 || dq_oe == 4'b0010 || dq_oe == 4'b0011 || dq_oe == 4'b1111)); // R2

  AST_IDLE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (nbits == '0 && !rd_act)); // R9
endmodule

// File: tb/sim_lock_reg_engine.sv
module sim_lock_reg_engine;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, erase_suspend = 1'b0;
  logic [3:0] dq_in = 4'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] dq_out, dq_oe;
  logic wel;
  int checks = 0, errors = 0;
  logic [1:0] mdl [128];
  logic mwel = 1'b0;

  always #5 clk = ~clk;

  lock_reg_engine u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .dq_in(dq_in),
    .mode(mode), .erase_suspend(erase_suspend), .dq_out(dq_out), .dq_oe(dq_oe), .wel(wel));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && cs_n) chk("R9 idle oe", dq_oe, 0);

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  function automatic int bw();
    return (mode == 2'd1) ? 2 : (mode == 2'd2) ? 4 : 1;
  endfunction

  function automatic logic [3:0] chunk(logic [7:0] t);
    int w = bw();
    return (w == 1) ? {3'b0, t[7]} : (w == 2) ? {2'b0, t[7:6]} : t[7:4];
  endfunction

  task automatic edge_in(logic [3:0] d);
    sck = 1'b0; dq_in = d; tick(2);
    sck = 1'b1; tick(2);
  endtask

  task automatic send_chunks(logic [7:0] b, int n);
    logic [7:0] t = b;
    for (int i = 0; i < n; i++) begin
      edge_in(chunk(t));
      t = t << bw();
    end
  endtask

  task automatic send_byte(logic [7:0] b); send_chunks(b, 8 / bw()); endtask

  task automatic frame_end();
    sck = 1'b0; tick(2); cs_n = 1'b1; tick(3);
  endtask

  task automatic wren();
    cs_n = 1'b0; tick(2);
    send_byte(8'h06);
    frame_end();
    mwel = 1'b1;
    chk("R3 wel set", wel, mwel);
  endtask

  // kind 0: exact 40 bits, 1: one chunk short, 2: one chunk extra
  task automatic wr_lock(logic [23:0] a, logic [7:0] d, int kind, string req);
    cs_n = 1'b0; tick(2);
    send_byte(8'hE5);
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    send_chunks(d, (kind == 1) ? 8 / bw() - 1 : 8 / bw());
    if (kind == 2) edge_in(4'hF);
    frame_end();
    if (kind == 0 && mwel) begin
      mdl[a[22:16]] = d[1:0];
      mwel = 1'b0;
    end
    chk(req, wel, mwel);
  endtask

  task automatic rd_lock(logic [23:0] a, int nbytes, string req);
    logic [7:0] t;
    logic [3:0] eoe, eout;
    int w;
    cs_n = 1'b0; tick(2);
    send_byte(8'hE8);
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    chk({req, " R7 no output before first fall"}, dq_oe, 0);
    w = bw();
    eoe = (w == 1) ? 4'b0010 : (w == 2) ? 4'b0011 : 4'b1111;
    for (int b = 0; b < nbytes; b++) begin
      t = {6'b0, mdl[a[22:16]]};
      for (int i = 0; i < 8 / w; i++) begin
        sck = 1'b0; tick(2);
        eout = (w == 1) ? {2'b0, t[7], 1'b0} : chunk(t);
        chk({req, " oe"}, dq_oe, eoe);
        chk({req, " data"}, dq_out, eout);
        t = t << w;
        sck = 1'b1; tick(2);
      end
    end
    frame_end();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) mdl[i] = 2'b00;
    tick(3); rst_n = 1'b1; tick(2);
    chk("R1 wel reset", wel, 0);
    chk("R1 oe reset", dq_oe, 0);
    rd_lock(24'h05_0000, 1, "R1 lock reset");

    wr_lock(24'h05_0000, 8'h03, 0, "R5 no wel write");
    rd_lock(24'h05_0000, 1, "R5 entry unchanged");

    mode = 2'd1;
    wren();
    wr_lock(24'h05_1234, 8'h03, 0, "R4 dual commit");
    rd_lock(24'h05_0000, 1, "R4 R2 dual readback");

    mode = 2'd0;
    wren();
    wr_lock(24'h06_0000, 8'h02, 1, "R5 short frame");
    wr_lock(24'h06_0000, 8'h02, 2, "R5 long frame");
    rd_lock(24'h06_0000, 1, "R5 sector 6 untouched");

    mode = 2'd2; erase_suspend = 1'b1;
    wr_lock(24'h7F_0000, 8'hFE, 0, "R6 commit in suspend");
    rd_lock(24'h7F_FFFF, 1, "R6 R4 quad readback upper bits dropped");
    erase_suspend = 1'b0;

    mode = 2'd3;
    wren();
    wr_lock(24'h85_0000, 8'h01, 0, "R10 bit23 ignored write");
    rd_lock(24'h05_0000, 1, "R10 R2 mode3 as single line");
    rd_lock(24'h04_0000, 1, "R10 neighbour sector");

    mode = 2'd1;
    rd_lock(24'h05_0000, 3, "R8 repeated readout");
    mode = 2'd2;
    rd_lock(24'h7F_0000, 4, "R8 quad repeat");

    mode = 2'd0;
    wren();
    cs_n = 1'b0; tick(2);
    send_byte(8'h9F);
    for (int i = 0; i < 5; i++) begin
      send_byte(8'hE5);
      chk("R9 unknown cmd oe", dq_oe, 0);
    end
    frame_end();
    chk("R9 unknown cmd wel", wel, mwel);
    rd_lock(24'h05_0000, 1, "R9 unknown cmd no state change");

    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(2);
    for (int i = 0; i < 128; i++) mdl[i] = 2'b00;
    mwel = 1'b0;
    chk("R1 wel after reset", wel, 0);
    rd_lock(24'h7F_0000, 1, "R1 lock cleared");
    rd_lock(24'h05_0000, 1, "R1 lock cleared");
    finish_run();
  end
endmodule